// File: doc/BRIEF.md
# Sample Phase Tuning Sweep Controller

This block steps a receive sample phase across every position of a clock period and keeps a pass/fail record for each position. It programs a phase through a request/acknowledge handshake, writes the data timeout value as all ones, and asks an external responder for one tuning transfer. The responder's pass or fail result goes into a 32-bit result mask at the bit for that phase. The sweep takes more steps than there are phases and the phase index wraps, so the last steps overwrite the results for the lowest phases.

When the sweep ends, a window finder looks for the longest run of passing phases in the mask. A run may wrap from the top phase to phase 0. The finder returns the centre of that run. If no phase passed, the controller pulses its error output and programs nothing more. Otherwise it programs the centre phase and then pulses done. After either ending, the final mask and the chosen phase stay on the outputs until the next start.

Top module: `phase_sweep_ctrl`

## Requirements
- R1: A start pulse accepted while idle clears the result mask to zero in the next cycle and begins a sweep whose first programmed phase is 0. A start pulse while a sweep or final step is in progress has no effect.
- R2: A sweep has exactly 40 steps. Step k programs phase k mod 32, so the programmed phases run 0..31 and then 0..7.
- R3: In each step the phase request stays high, with a stable phase, until it is acknowledged. In the cycle after the acknowledge the timeout write strobe pulses for one cycle with an all-ones value. The tuning request rises in the cycle after that.
- R4: The tuning request stays high until a response is valid. A pass sets the mask bit at the current phase and a fail clears it. Because of this, bits 0..7 end with the results of steps 32..39.
- R5: The finder picks the longest circular run of ones. A candidate start is a set bit at position 0, or a set bit whose lower neighbour is clear. On equal lengths the lowest candidate start wins. The centre is (start + floor(length/2)) mod 32. An all-ones mask gives phase 0.
- R6: If the final mask is zero, error pulses. No final phase is programmed, so the sweep makes 40 phase requests in total, and the reported best phase keeps its previous value.
- R7: If any phase passed, a 41st phase request carries the centre phase. Done pulses in the cycle after that request is acknowledged. Done and error are never high together.
- R8: Done and error are high for one cycle only. The mask and best phase hold their values after the pulse until a new start is accepted.
- R9: A start that arrives in the same cycle as the done pulse is accepted and begins a new sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a sweep (accepted when idle) |
| prog_req_o | output | 1 | Phase program request |
| prog_phase_o | output | 5 | Phase to program |
| prog_ack_i | input | 1 | Phase program acknowledge |
| tmo_wr_o | output | 1 | Data timeout write strobe |
| tmo_val_o | output | 32 | Data timeout value (all ones) |
| tune_req_o | output | 1 | Tuning transfer request |
| tune_rsp_valid_i | input | 1 | Tuning response valid |
| tune_pass_i | input | 1 | Tuning result: 1 pass, 0 fail |
| done_o | output | 1 | Success pulse |
| error_o | output | 1 | No-pass pulse |
| mask_o | output | 32 | Result mask, bit n is phase n |
| best_phase_o | output | 5 | Chosen centre phase |

## Verification
The end of one sweep and the start of the next can fall in the same cycle. The bench waits until it sees the done pulse and raises start in that same cycle. In that cycle it checks that the mask still holds the old result. One cycle later it checks that the mask reads zero. It then lets the new sweep run to completion and checks its own result. A second collision comes from a responder that acknowledges with zero latency, so the request and the acknowledge share a cycle. This is repeated with one- and two-cycle latencies, and in every case the step count and the phase order must come out the same.

// File: rtl/phase_tune_pkg.sv
package phase_tune_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_TMO,
    ST_TUNE,
    ST_FIND,
    ST_FINAL
  } sweep_state_e;
endpackage

// File: rtl/pts_step_counter.sv
module pts_step_counter #(
  parameter int STEPS  = 40,
  parameter int PHASES = 32,
  parameter int PW     = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [PW-1:0] phase_o,
  output logic          last_o
);
  localparam int SW = $clog2(STEPS);

  logic [SW-1:0] step_q;
  logic [PW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= '0;
      phase_q <= '0;
    end else if (clr_i) begin
      step_q  <= '0;
      phase_q <= '0;
    end else if (adv_i) begin
      step_q  <= step_q + 1'b1;
      phase_q <= (phase_q == PW'(PHASES - 1)) ? '0 : phase_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
  assign last_o  = (step_q == SW'(STEPS - 1));
endmodule

// File: rtl/pts_result_mask.sv
module pts_result_mask #(
  parameter int PHASES = 32,
  parameter int PW     = $clog2(PHASES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [PW-1:0]     idx_i,
  input  logic              val_i,
  output logic [PHASES-1:0] mask_o
);
  logic [PHASES-1:0] mask_q;

  for (genvar b = 0; b < PHASES; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mask_q[b] <= 1'b0;
      else if (clr_i)
        mask_q[b] <= 1'b0;
      else if (wr_i && (idx_i == PW'(b)))
        mask_q[b] <= val_i;
    end
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/pts_window_finder.sv
module pts_window_finder #(
  parameter int PHASES = 32,
  parameter int PW     = $clog2(PHASES)
) (
  input  logic [PHASES-1:0] mask_i,
  output logic              found_o,
  output logic [PW-1:0]     centre_o
);
  // Length of the run of ones that begins at s, following the wrap.
  function automatic int run_from(input logic [PHASES-1:0] m, input int s);
    int  n;
    bit  stop;
    n    = 0;
    stop = 1'b0;
    for (int k = 0; k < PHASES; k++) begin
      if (!stop && m[(s + k) % PHASES]) n = n + 1;
      else stop = 1'b1;
    end
    return n;
  endfunction

  // Centre of the longest run; on equal lengths the lowest start wins.
  function automatic int centre_of(input logic [PHASES-1:0] m);
    int  best_len;
    int  best_s;
    int  len;
    bit  elig;
    best_len = 0;
    best_s   = 0;
    if (&m) return 0;
    for (int s = 0; s < PHASES; s++) begin
      elig = m[s] && ((s == 0) || !m[(s + PHASES - 1) % PHASES]);
      len  = run_from(m, s);
      if (elig && (len > best_len)) begin
        best_len = len;
        best_s   = s;
      end
    end
    return (best_s + best_len / 2) % PHASES;
  endfunction

  assign found_o  = |mask_i;
  assign centre_o = PW'(centre_of(mask_i));
endmodule

// File: rtl/phase_sweep_ctrl.sv
module phase_sweep_ctrl #(
  parameter int STEPS  = 40,
  parameter int PHASES = 32,
  parameter int TMO_W  = 32,
  parameter int PW     = $clog2(PHASES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              prog_req_o,
  output logic [PW-1:0]     prog_phase_o,
  input  logic              prog_ack_i,
  output logic              tmo_wr_o,
  output logic [TMO_W-1:0]  tmo_val_o,
  output logic              tune_req_o,
  input  logic              tune_rsp_valid_i,
  input  logic              tune_pass_i,
  output logic              done_o,
  output logic              error_o,
  output logic [PHASES-1:0] mask_o,
  output logic [PW-1:0]     best_phase_o
);
  import phase_tune_pkg::*;

  sweep_state_e      state_q, state_d;
  logic [PW-1:0]     best_q;
  logic              done_q, err_q;

  // Named internal events
  logic              start_accept_w;
  logic              prog_fire_w;
  logic              tune_fire_w;
  logic              sweep_last_w;
  logic              step_adv_w;
  logic [PW-1:0]     cur_phase_w;
  logic              found_w;
  logic [PW-1:0]     centre_w;

  assign start_accept_w = (state_q == ST_IDLE) && start_i;
  assign prog_fire_w    = prog_req_o && prog_ack_i;
  assign tune_fire_w    = (state_q == ST_TUNE) && tune_rsp_valid_i;
  assign step_adv_w     = tune_fire_w && !sweep_last_w;

  pts_step_counter #(.STEPS(STEPS), .PHASES(PHASES), .PW(PW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (start_accept_w),
    .adv_i   (step_adv_w),
    .phase_o (cur_phase_w),
    .last_o  (sweep_last_w)
  );

  pts_result_mask #(.PHASES(PHASES), .PW(PW)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (start_accept_w),
    .wr_i   (tune_fire_w),
    .idx_i  (cur_phase_w),
    .val_i  (tune_pass_i),
    .mask_o (mask_o)
  );

  pts_window_finder #(.PHASES(PHASES), .PW(PW)) u_find (
    .mask_i   (mask_o),
    .found_o  (found_w),
    .centre_o (centre_w)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_PROG;
      ST_PROG:  if (prog_ack_i) state_d = ST_TMO;
      ST_TMO:   state_d = ST_TUNE;
      ST_TUNE:  if (tune_rsp_valid_i) state_d = sweep_last_w ? ST_FIND : ST_PROG;
      ST_FIND:  state_d = found_w ? ST_FINAL : ST_IDLE;
      ST_FINAL: if (prog_ack_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      best_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_FINAL) && prog_ack_i;
      err_q   <= (state_q == ST_FIND) && !found_w;
      if ((state_q == ST_FIND) && found_w)
        best_q <= centre_w;
    end
  end

  assign prog_req_o   = (state_q == ST_PROG) || (state_q == ST_FINAL);
  assign prog_phase_o = (state_q == ST_FINAL) ? best_q : cur_phase_w;
  assign tmo_wr_o     = (state_q == ST_TMO);
  assign tmo_val_o    = {TMO_W{1'b1}};
  assign tune_req_o   = (state_q == ST_TUNE);
  assign done_o       = done_q;
  assign error_o      = err_q;
  assign best_phase_o = best_q;
endmodule

// File: rtl/phase_sweep_ctrl_chk.sv
module phase_sweep_ctrl_chk #(
  parameter int PHASES = 32,
  parameter int PW     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              prog_req_o,
  input logic [PW-1:0]     prog_phase_o,
  input logic              prog_ack_i,
  input logic              tmo_wr_o,
  input logic              tune_req_o,
  input logic              tune_rsp_valid_i,
  input logic              done_o,
  input logic              error_o,
  input logic [PHASES-1:0] mask_o,
  input logic [PW-1:0]     best_phase_o
);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req_o && !prog_ack_i |=> prog_req_o && $stable(prog_phase_o));
  // R3
  tmo_before_tune_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tune_req_o) |-> $past(tmo_wr_o));
  // R3
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_req_o && tune_req_o));
  // R4
  tune_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tune_req_o && !tune_rsp_valid_i |=> tune_req_o);
  // R7
  end_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && error_o));
  // R6
  err_best_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> $stable(best_phase_o));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R8
  error_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |=> !error_o);
  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> $stable(mask_o) && $stable(best_phase_o));
endmodule

bind phase_sweep_ctrl phase_sweep_ctrl_chk #(.PHASES(PHASES), .PW(PW)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .start_i          (start_i),
  .prog_req_o       (prog_req_o),
  .prog_phase_o     (prog_phase_o),
  .prog_ack_i       (prog_ack_i),
  .tmo_wr_o         (tmo_wr_o),
  .tune_req_o       (tune_req_o),
  .tune_rsp_valid_i (tune_rsp_valid_i),
  .done_o           (done_o),
  .error_o          (error_o),
  .mask_o           (mask_o),
  .best_phase_o     (best_phase_o)
);

// File: tb/sim_phase_sweep_ctrl.sv
`timescale 1ns/1ps
module sim_phase_sweep_ctrl;
  localparam int NV = 9;
  // pattern bit k = result returned for step k
  localparam logic [39:0] PAT [NV] = '{
    40'hFF_FFFFFFFF, 40'h00_FFFFFFFF, 40'h03_F0000C03, 40'h00_00000000,
    40'h3C_00000000, 40'hF0_00F000F0, 40'h00_80000000, 40'h00_00000E00,
    40'h81_000000FF};
  localparam logic [31:0] EXP_MASK [NV] = '{
    32'hFFFFFFFF, 32'hFFFFFF00, 32'hF0000C03, 32'h00000000,
    32'h0000003C, 32'h00F000F0, 32'h80000000, 32'h00000E00,
    32'h00000081};
  localparam int EXP_BEST [NV] = '{0, 20, 31, 31, 4, 6, 31, 10, 0};
  localparam bit EXP_ERR  [NV] = '{0, 0, 0, 1, 0, 0, 0, 0, 0};
  localparam int LAT      [NV] = '{0, 1, 2, 0, 1, 0, 2, 1, 0};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic prog_ack = 1'b0, tune_vld = 1'b0, tune_pass = 1'b0;
  logic prog_req, tmo_wr, tune_req, done, err;
  logic [4:0]  prog_phase, best;
  logic [31:0] tmo_val, mask;

  int checks = 0, errors = 0;
  int n_prog, n_tune, n_tmo, n_done, n_err, order_bad, last_phase, lat, pw, tw;
  logic [39:0] pat;

  always #4 clk = ~clk;

  phase_sweep_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .prog_req_o(prog_req), .prog_phase_o(prog_phase), .prog_ack_i(prog_ack),
    .tmo_wr_o(tmo_wr), .tmo_val_o(tmo_val), .tune_req_o(tune_req),
    .tune_rsp_valid_i(tune_vld), .tune_pass_i(tune_pass),
    .done_o(done), .error_o(err), .mask_o(mask), .best_phase_o(best));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    n_prog = 0; n_tune = 0; n_tmo = 0; n_done = 0; n_err = 0;
    order_bad = 0; last_phase = -1; pw = 0; tw = 0;
  endtask

  // Responder: acts on the falling edge only
  initial begin
    clear_counts();
    lat = 0; pat = '0;
    forever begin
      @(negedge clk);
      prog_ack = 1'b0;
      tune_vld = 1'b0;
      if (done) n_done++;
      if (err) n_err++;
      if (tmo_wr) begin
        n_tmo++;
        if (tmo_val !== 32'hFFFFFFFF) order_bad++;
      end
      if (prog_req) begin
        if (pw >= lat) begin
          prog_ack = 1'b1;
          if (n_prog < 40 && prog_phase !== 5'(n_prog % 32)) order_bad++;
          last_phase = int'(prog_phase);
          n_prog++;
          pw = 0;
        end else pw++;
      end
      if (tune_req) begin
        if (tw >= lat) begin
          tune_vld  = 1'b1;
          tune_pass = pat[n_tune % 40];
          n_tune++;
          tw = 0;
        end else tw++;
      end
    end
  end

  task automatic wait_end(output bit hung);
    hung = 1'b1;
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      if (n_done + n_err > 0) begin hung = 1'b0; break; end
    end
  endtask

  task automatic run_vec(input int v, input bit mid_start);
    bit hung;
    @(negedge clk);
    clear_counts();
    pat = PAT[v]; lat = LAT[v];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check($sformatf("R1 mask cleared v%0d", v), mask, 32'h0);
    if (mid_start) begin
      repeat (60) @(negedge clk);
      start = 1'b1;              // R1: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    wait_end(hung);
    repeat (4) @(negedge clk);
    check($sformatf("R4 mask v%0d", v), mask, EXP_MASK[v]);
    check($sformatf("R5 best v%0d", v), 32'(best), 32'(EXP_BEST[v]));
    check($sformatf("R6 error v%0d", v), 32'(n_err), 32'(EXP_ERR[v]));
    check($sformatf("R8 done count v%0d", v), 32'(n_done), EXP_ERR[v] ? 32'd0 : 32'd1);
    check($sformatf("R2 tune steps v%0d", v), 32'(n_tune), 32'd40);
    check($sformatf("R3 tmo writes v%0d", v), 32'(n_tmo), 32'd40);
    check($sformatf("R2 phase order v%0d", v), 32'(order_bad), 32'd0);
    check($sformatf("R7 prog count v%0d", v), 32'(n_prog), EXP_ERR[v] ? 32'd40 : 32'd41);
    if (!EXP_ERR[v])
      check($sformatf("R7 final phase v%0d", v), 32'(last_phase), 32'(EXP_BEST[v]));
  endtask

  initial begin
    bit hung;
    repeat (3) @(negedge clk);
    check("R8 reset mask", mask, 32'h0);
    check("R8 reset best", 32'(best), 32'h0);
    check("R3 reset reqs", {29'd0, prog_req, tune_req, tmo_wr}, 32'h0);
    check("R8 reset pulses", {30'd0, done, err}, 32'h0);
    rst_n = 1'b1;
    for (int v = 0; v < NV; v++) run_vec(v, v == 2);

    // R9: start raised in the cycle of the done pulse
    @(negedge clk);
    clear_counts();
    pat = PAT[1]; lat = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 2000 && !done; c++) @(negedge clk);
    check("R8 mask held in done cycle", mask, EXP_MASK[1]);
    pat = PAT[7];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9 restart clears mask", mask, 32'h0);
    clear_counts();
    wait_end(hung);
    repeat (3) @(negedge clk);
    check("R9 restart sweep mask", mask, EXP_MASK[7]);
    check("R9 restart best", 32'(best), 32'(EXP_BEST[7]));
    check("R9 restart done", 32'(n_done), 32'd1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule